// File: doc/BRIEF.md
# Polyphase Fractional-Rate Interpolator

The block resamples a stream of signed 16-bit samples by a rational factor. The factor can be any value up to, but not including, the number of polyphase branches. Its base is a 64-branch polyphase FIR with 4 taps per branch. A 16-bit phase accumulator tracks where each output falls between two input samples. The top 6 accumulator bits pick a branch. The low 10 bits are the blend weight.

For every output, the block evaluates the selected branch and the branch one step above it. It then mixes the two results linearly by the weight, rounds, and saturates to 16 bits. When the accumulator passes a full input period, the block takes exactly one new input sample before it computes the next output. It holds its ready line high only while it waits for that sample.

The step is a static configuration value. Each output advances the accumulator by the step, so the number of outputs per input sample is 65536 divided by the step. Coefficients come from a compile-time parameter table.

Top module: `frac_resampler`

## Requirements
- R1: During reset and in the first cycle after it, `in_ready` is 1 and `out_valid` is 0. The tap delay line and the accumulator both start at zero.
- R2: Each computed output advances the 16-bit accumulator by `cfg_step` modulo 65536. Bits 15..10 select the lower branch b, and bits 9..0 form the weight f.
- R3: An output whose weight is 512 (for example phase 3/128, which is b=1 and f=512) is the equal-weight mix of branches b and b+1.
- R4: Branch p evaluates to B(p) = sum over t=0..3 of c(p,t)*x[m-t], where x[m] is the older of the two samples around the phase and x[m+1] is the newest sample taken. The coefficient is c(p,t) = ((64*t+p)*1237+311) mod 65536, read as two's complement 16-bit. The output is floor((B(b)*(1024-f) + B(b+1)*f + 2^24) / 2^25).
- R5: A result above 32767 or below -32768 is clamped to that limit.
- R6: When b is 63, the upper neighbour is branch 0 applied to the window advanced by one sample: sum of c(0,t)*x[m+1-t].
- R7: If adding the step carries out of bit 15, `in_ready` rises on the next cycle. The cycle with `in_ready` and `in_valid` both high loads the sample and computes no output. Computation resumes on the following cycle. Data offered while `in_ready` is low is ignored.
- R8: While a sample is pending and `in_valid` is low, the accumulator holds, no new outputs start, and `in_ready` stays high.
- R9: An output computed in cycle n appears with a one-cycle `out_valid` pulse after the second rising edge that follows cycle n.
- R10: After reset, the block accepts one sample before its first output. That first output lies between a zero sample and the first sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_step | input | 16 | Accumulator increment per output, held static |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Block waits for a sample |
| in_data | input | 16 | Signed input sample |
| out_valid | output | 1 | Output sample valid pulse |
| out_data | output | 16 | Signed output sample |

## Verification
The bench pushes the accumulator onto branch 63 again and again with steps close to a full period. A design that wrapped the upper neighbour to branch 0 without advancing the window would then produce a visibly wrong mix. A step of 1536 lands exactly on weight 512, so a swapped or off-by-one weight shows up at once. Full-range random samples drive the mix past both limits, which exposes wrap-around in place of clamping. Random gaps in `in_valid` test the stall: a design that kept computing, moved the phase, or dropped ready while waiting would desynchronise from the cycle model.

// File: rtl/frac_resampler_pkg.sv
package frac_resampler_pkg;

    localparam int DATA_W  = 16;
    localparam int COEF_W  = 16;
    localparam int BR_BITS = 6;
    localparam int FRAC_W  = 10;
    localparam int TAPS    = 4;
    localparam int NBR     = 1 << BR_BITS;

    typedef enum logic {
        PH_FILL = 1'b0,
        PH_RUN  = 1'b1
    } phase_state_e;

    function automatic logic [COEF_W-1:0] coef_seed(input int idx);
        int v;
        v = (idx * 1237 + 311) % 65536;
        return v[COEF_W-1:0];
    endfunction

    // Packed table: entry (branch*TAPS + tap) holds c(branch, tap).
    function automatic logic [NBR*TAPS*COEF_W-1:0] default_table();
        logic [NBR*TAPS*COEF_W-1:0] tbl;
        tbl = '0;
        for (int p = 0; p < NBR; p++) begin
            for (int t = 0; t < TAPS; t++) begin
                tbl[(p*TAPS + t)*COEF_W +: COEF_W] = coef_seed(t*NBR + p);
            end
        end
        return tbl;
    endfunction

endpackage

// File: rtl/frac_resampler_phase.sv
module frac_resampler_phase
    import frac_resampler_pkg::*;
#(
    parameter int ACC_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [ACC_W-1:0] step,
    input  logic             in_valid,
    output logic             in_ready,
    output logic             issue,
    output logic [ACC_W-1:0] acc
);

    phase_state_e     state_q;
    logic [ACC_W-1:0] acc_q;
    logic [ACC_W:0]   acc_sum;

    assign acc_sum  = {1'b0, acc_q} + {1'b0, step};
    assign issue    = (state_q == PH_RUN);
    assign in_ready = (state_q == PH_FILL);
    assign acc      = acc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PH_FILL;
            acc_q   <= '0;
        end else if (state_q == PH_RUN) begin
            acc_q <= acc_sum[ACC_W-1:0];
            if (acc_sum[ACC_W]) begin
                state_q <= PH_FILL;
            end
        end else if (in_valid) begin
            state_q <= PH_RUN;
        end
    end

endmodule

// File: rtl/frac_resampler_window.sv
module frac_resampler_window #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 5
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    shift_en,
    input  logic [DATA_W-1:0]       din,
    output logic [DEPTH*DATA_W-1:0] win
);

    // Slot 0 holds the newest sample; slot k the sample k periods older.
    logic [DATA_W-1:0] slot_q [DEPTH];

    for (genvar k = 0; k < DEPTH; k++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                slot_q[k] <= '0;
            end else if (shift_en) begin
                if (k == 0) begin
                    slot_q[k] <= din;
                end else begin
                    slot_q[k] <= slot_q[k-1];
                end
            end
        end
        assign win[k*DATA_W +: DATA_W] = slot_q[k];
    end

endmodule

// File: rtl/frac_resampler_mac.sv
module frac_resampler_mac #(
    parameter int DATA_W = 16,
    parameter int COEF_W = 16,
    parameter int TAPS   = 4,
    parameter int SUM_W  = 34
) (
    input  logic [TAPS*COEF_W-1:0]   coefs,
    input  logic [TAPS*DATA_W-1:0]   samples,
    output logic signed [SUM_W-1:0]  sum
);

    localparam int PROD_W = DATA_W + COEF_W;

    logic signed [PROD_W-1:0] prod [TAPS];

    for (genvar t = 0; t < TAPS; t++) begin : g_tap
        assign prod[t] = PROD_W'($signed(samples[t*DATA_W +: DATA_W]))
                       * PROD_W'($signed(coefs[t*COEF_W +: COEF_W]));
    end

    always_comb begin
        sum = '0;
        for (int t = 0; t < TAPS; t++) begin
            sum = sum + SUM_W'(prod[t]);
        end
    end

endmodule

// File: rtl/frac_resampler_blend.sv
module frac_resampler_blend #(
    parameter int DATA_W = 16,
    parameter int COEF_W = 16,
    parameter int FRAC_W = 10,
    parameter int SUM_W  = 34
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic signed [SUM_W-1:0]  lo,
    input  logic signed [SUM_W-1:0]  hi,
    input  logic [FRAC_W-1:0]        frac,
    output logic                     out_valid,
    output logic [DATA_W-1:0]        out_data
);

    localparam int BL_W  = SUM_W + FRAC_W + 3;
    localparam int SHIFT = COEF_W - 1 + FRAC_W;
    localparam logic signed [BL_W-1:0] MAXV = (BL_W'(1) <<< (DATA_W-1)) - BL_W'(1);
    localparam logic signed [BL_W-1:0] MINV = ~MAXV;
    localparam logic signed [BL_W-1:0] HALF = BL_W'(1) <<< (SHIFT-1);

    logic [FRAC_W:0]          w_hi, w_lo;
    logic signed [BL_W-1:0]   mix, rnd, shr;
    logic [DATA_W-1:0]        res;

    always_comb begin
        w_hi = {1'b0, frac};
        w_lo = (FRAC_W+1)'(1 << FRAC_W) - w_hi;
        mix  = BL_W'(lo) * $signed(BL_W'(w_lo)) + BL_W'(hi) * $signed(BL_W'(w_hi));
        rnd  = mix + HALF;
        shr  = rnd >>> SHIFT;
        if (shr > MAXV) begin
            res = MAXV[DATA_W-1:0];
        end else if (shr < MINV) begin
            res = MINV[DATA_W-1:0];
        end else begin
            res = shr[DATA_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_data <= res;
            end
        end
    end

endmodule

// File: rtl/frac_resampler.sv
module frac_resampler
    import frac_resampler_pkg::*;
#(
    parameter int DATA_W_P  = frac_resampler_pkg::DATA_W,
    parameter int COEF_W_P  = frac_resampler_pkg::COEF_W,
    parameter int BR_BITS_P = frac_resampler_pkg::BR_BITS,
    parameter int FRAC_W_P  = frac_resampler_pkg::FRAC_W,
    parameter int TAPS_P    = frac_resampler_pkg::TAPS,
    parameter logic [(1<<BR_BITS_P)*TAPS_P*COEF_W_P-1:0] COEF_TABLE =
        frac_resampler_pkg::default_table()
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic [BR_BITS_P+FRAC_W_P-1:0]      cfg_step,
    input  logic                               in_valid,
    output logic                               in_ready,
    input  logic [DATA_W_P-1:0]                in_data,
    output logic                               out_valid,
    output logic [DATA_W_P-1:0]                out_data
);

    localparam int ACC_W = BR_BITS_P + FRAC_W_P;
    localparam int DEPTH = TAPS_P + 1;
    localparam int SUM_W = DATA_W_P + COEF_W_P + $clog2(TAPS_P);

    logic                     issue;
    logic [ACC_W-1:0]         acc;
    logic [DEPTH*DATA_W_P-1:0] win;
    logic [BR_BITS_P-1:0]     br_lo, br_hi;
    logic                     edge_hi;
    logic [FRAC_W_P-1:0]      frac;

    logic [TAPS_P*COEF_W_P-1:0] coef_lo, coef_hi;
    logic [TAPS_P*DATA_W_P-1:0] samp_lo, samp_hi;
    logic signed [SUM_W-1:0]    sum_lo, sum_hi;

    logic                     s1_valid;
    logic signed [SUM_W-1:0]  s1_lo, s1_hi;
    logic [FRAC_W_P-1:0]      s1_frac;

    frac_resampler_phase #(.ACC_W(ACC_W)) phase_i (
        .clk      (clk),
        .rst      (rst),
        .step     (cfg_step),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .issue    (issue),
        .acc      (acc)
    );

    frac_resampler_window #(.DATA_W(DATA_W_P), .DEPTH(DEPTH)) window_i (
        .clk      (clk),
        .rst      (rst),
        .shift_en (in_ready & in_valid),
        .din      (in_data),
        .win      (win)
    );

    assign br_lo   = acc[ACC_W-1 -: BR_BITS_P];
    assign br_hi   = br_lo + 1'b1;
    assign edge_hi = &br_lo;
    assign frac    = acc[FRAC_W_P-1:0];

    // Lower branch reads slots 1..TAPS; the upper one shifts to slots
    // 0..TAPS-1 when it wraps past the last branch.
    for (genvar t = 0; t < TAPS_P; t++) begin : g_sel
        assign coef_lo[t*COEF_W_P +: COEF_W_P] =
            COEF_TABLE[(int'(br_lo)*TAPS_P + t)*COEF_W_P +: COEF_W_P];
        assign coef_hi[t*COEF_W_P +: COEF_W_P] =
            COEF_TABLE[(int'(br_hi)*TAPS_P + t)*COEF_W_P +: COEF_W_P];
        assign samp_lo[t*DATA_W_P +: DATA_W_P] = win[(t+1)*DATA_W_P +: DATA_W_P];
        assign samp_hi[t*DATA_W_P +: DATA_W_P] = edge_hi
            ? win[t*DATA_W_P +: DATA_W_P]
            : win[(t+1)*DATA_W_P +: DATA_W_P];
    end

    frac_resampler_mac #(.DATA_W(DATA_W_P), .COEF_W(COEF_W_P), .TAPS(TAPS_P), .SUM_W(SUM_W)) mac_lo_i (
        .coefs   (coef_lo),
        .samples (samp_lo),
        .sum     (sum_lo)
    );

    frac_resampler_mac #(.DATA_W(DATA_W_P), .COEF_W(COEF_W_P), .TAPS(TAPS_P), .SUM_W(SUM_W)) mac_hi_i (
        .coefs   (coef_hi),
        .samples (samp_hi),
        .sum     (sum_hi)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid <= 1'b0;
            s1_lo    <= '0;
            s1_hi    <= '0;
            s1_frac  <= '0;
        end else begin
            s1_valid <= issue;
            if (issue) begin
                s1_lo   <= sum_lo;
                s1_hi   <= sum_hi;
                s1_frac <= frac;
            end
        end
    end

    frac_resampler_blend #(.DATA_W(DATA_W_P), .COEF_W(COEF_W_P), .FRAC_W(FRAC_W_P), .SUM_W(SUM_W)) blend_i (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (s1_valid),
        .lo        (s1_lo),
        .hi        (s1_hi),
        .frac      (s1_frac),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

endmodule

// File: rtl/frac_resampler_chk.sv
module frac_resampler_chk #(
    parameter int ACC_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             in_ready,
    input logic             out_valid,
    input logic             issue,
    input logic             s1_valid,
    input logic [ACC_W-1:0] acc
);

    // R1
    ready_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (in_ready && !out_valid));

    // R7
    single_load_chk: assert property (@(posedge clk) disable iff (rst)
        (in_ready && in_valid) |=> (!in_ready && issue));

    // R7
    no_issue_in_fill_chk: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> !issue);

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (in_ready && !in_valid) |=> (in_ready && $stable(acc)));

    // R2
    acc_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !issue |=> $stable(acc));

    // R9
    out_follow_chk: assert property (@(posedge clk) disable iff (rst)
        s1_valid |=> out_valid);

    // R9
    out_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !s1_valid |=> !out_valid);

endmodule

bind frac_resampler frac_resampler_chk #(.ACC_W(ACC_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .issue     (issue),
    .s1_valid  (s1_valid),
    .acc       (acc)
);

// File: tb/frac_resampler_tb_top.sv
`timescale 1ns/1ps
module frac_resampler_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cfg_step = 16'd1536;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] in_data = '0;
    logic        out_valid;
    logic [15:0] out_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    frac_resampler dut_i (
        .clk       (clk),
        .rst       (rst),
        .cfg_step  (cfg_step),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    // ---------------- reference model ----------------
    longint m_win [5];
    int     m_acc;
    bit     m_need;
    bit     m_p1v, m_ov;
    longint m_p1d, m_od;
    string  m_p1tag, m_otag;
    int     outs_seen;

    function automatic longint coef(int p, int t);
        int v;
        v = ((64*t + p) * 1237 + 311) % 65536;
        if (v >= 32768) v = v - 65536;
        return longint'(v);
    endfunction

    task automatic model_reset();
        for (int k = 0; k < 5; k++) m_win[k] = 0;
        m_acc = 0; m_need = 1; m_p1v = 0; m_ov = 0; m_p1d = 0; m_od = 0;
        m_p1tag = "R4"; m_otag = "R4";
    endtask

    task automatic model_step(bit v, logic [15:0] d, int step);
        longint lo, hi, mix, r;
        int br, f;
        string tag;
        m_ov = m_p1v; m_od = m_p1d; m_otag = m_p1tag;
        if (m_need) begin
            m_p1v = 0;
            if (v) begin
                for (int k = 4; k > 0; k--) m_win[k] = m_win[k-1];
                m_win[0] = longint'($signed(d));
                m_need = 0;
            end
        end else begin
            br = m_acc >> 10; f = m_acc & 1023;
            lo = 0; hi = 0;
            for (int t = 0; t < 4; t++) begin
                lo += coef(br, t) * m_win[t+1];
                if (br == 63) hi += coef(0, t) * m_win[t];
                else          hi += coef(br+1, t) * m_win[t+1];
            end
            mix = lo * (1024 - f) + hi * f;
            r = (mix + (longint'(1) << 24)) >>> 25;
            tag = "R4 (R2 phase)";
            if (f == 512) tag = "R3";
            if (br == 63) tag = "R6";
            if (r > 32767)  begin r = 32767;  tag = "R5"; end
            if (r < -32768) begin r = -32768; tag = "R5"; end
            m_p1v = 1; m_p1d = r; m_p1tag = tag;
            m_acc += step;
            if (m_acc >= 65536) begin m_acc -= 65536; m_need = 1; end
        end
    endtask

    task automatic check(bit ok, string req, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic do_reset(int step);
        rst = 1; in_valid = 0; cfg_step = 16'(step);
        model_reset();
        repeat (3) @(negedge clk);
        // R1: reset state while held
        check(in_ready === 1'b1, "R1 ready", longint'(in_ready), 1);
        check(out_valid === 1'b0, "R1 valid", longint'(out_valid), 0);
        rst = 0;
        outs_seen = 0;
    endtask

    // mode: 0 ramp always valid, 1 full-range always valid,
    //       2 moderate random with gaps, 3 full-range with gaps
    task automatic run(int ncyc, int mode, int step);
        for (int c = 0; c < ncyc; c++) begin
            bit v;
            logic [15:0] d;
            @(negedge clk);
            v = 1;
            if (mode >= 2) v = (($urandom % 10) < 4);
            case (mode)
                0: d = 16'(c*97 - 3000);
                1, 3: d = 16'($urandom);
                default: d = 16'(int'($urandom % 4001) - 2000);
            endcase
            in_valid = v; in_data = d;
            // R7: ready only while a sample is pending (R10 at start-up)
            check(in_ready === m_need, (outs_seen == 0) ? "R10" : "R7",
                  longint'(in_ready), longint'(m_need));
            // R8 / R9: output pulse timing
            check(out_valid === m_ov, m_need ? "R8" : "R9",
                  longint'(out_valid), longint'(m_ov));
            if (m_ov && out_valid === 1'b1) begin
                check($signed(out_data) == m_od, m_otag,
                      longint'($signed(out_data)), m_od);
                outs_seen++;
            end
            model_step(v, d, step);
        end
    endtask

    initial begin
        do_reset(1536);  run(80, 0, 1536);    // R3 halfway phases
        do_reset(1536);  run(200, 1, 1536);   // R5 clamping
        do_reset(65000); run(300, 3, 65000);  // R6 branch 63 often
        do_reset(4000);  run(400, 2, 4000);   // R8 stalls
        do_reset(1025);  run(300, 2, 1025);   // R2 ratio just under 64
        do_reset(65535); run(200, 1, 65535);  // R6 near one-to-one
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule